// File: doc/BRIEF.md
# Prioritized Eight-Source Interrupt Controller

This block collects event flags from eight peripheral sources and turns them into a single prioritized interrupt toward a processor core. It sits in an 8-bit I/O port space and holds three registers: a vector base, an enable mask and a status latch. Software writes a fourth port to acknowledge and clear status bits. Each peripheral sets or clears its own status bit through dedicated per-source strobes. The source assignment by bit is: 0 serial transmit, 1 input, 2 cartridge, 3 serial receive, 4 line compare, 5 vertical-blank timer, 6 vertical blank, 7 horizontal-blank timer.

At every instruction boundary the core presents a boundary strobe. With that strobe it also supplies an inhibit flag, which the core raises when the instruction just finished must not be followed by a poll: a segment, repeat or lock prefix, a stack-segment load, the set-interrupt-flag instruction, a flag pop, or a return from interrupt. When a poll is allowed and some enabled source is flagged, the controller always gives a wake pulse that releases a halted core, even while the core's interrupt flag is clear. When that flag is set, the controller also raises a request that carries the vector number. The vector number is the base plus the index of the highest-numbered pending source. The core reads the vector-table entry at four times the vector number in segment 0, with the offset at +0 and the segment at +2.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the base, enable and status registers are all 0x00. `irq_req` and `wake` are low. In colour mode (`color_mode`=1) reads of ports 0xB0, 0xB2 and 0xB4 return 0x00. In monochrome mode (`color_mode`=0) a read of 0xB0 returns 0x03.
- R2: A write to port 0xB0 stores the data with bits 2..0 cleared when `color_mode`=0. It stores the data with only bit 0 cleared when `color_mode`=1.
- R3: A read of port 0xB0 returns the stored base with bits 1..0 forced to 1 when `color_mode`=0. It returns the stored base unchanged when `color_mode`=1.
- R4: Port 0xB2 is the enable mask and can be read and written. Port 0xB4 reads the status latch. A read of any other port, 0xB6 included, returns 0x00.
- R5: A write to port 0xB6 clears every status bit written as 1 and leaves the other status bits unchanged.
- R6: `src_set[i]` sets status bit i and `src_clr[i]` clears it. When `src_set[i]` arrives in the same cycle as `src_clr[i]` or as an acknowledge write with bit i set, the bit ends set.
- R7: A source is pending when its status bit and its enable bit are both 1. A status bit whose enable bit is 0 causes neither a wake pulse nor a request.
- R8: In the cycle after `boundary`=1 with `inhibit`=0 while some source is pending, `wake` is high for exactly one cycle. This happens regardless of `cpu_if`.
- R9: A boundary with `inhibit`=1 produces no `wake` pulse and no request.
- R10: A request is issued only if `cpu_if`=1 at an allowed boundary with a source pending. `irq_req` rises in the next cycle. `irq_vector` then equals base plus the highest pending index, modulo 256.
- R11: Once raised, `irq_req` and `irq_vector` hold steady, even across further boundaries, until `irq_accept` is pulsed. `irq_req` is low in the cycle after the accept. Exactly one vector is delivered per accepted poll.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| color_mode | input | 1 | 1 = colour model base handling, 0 = monochrome |
| io_wr | input | 1 | Port write strobe |
| io_addr | input | 8 | Port address |
| io_wdata | input | 8 | Port write data |
| io_rdata | output | 8 | Port read data (combinational from `io_addr`) |
| src_set | input | 8 | Per-source status set strobes |
| src_clr | input | 8 | Per-source status clear strobes |
| boundary | input | 1 | Instruction-boundary poll strobe |
| inhibit | input | 1 | Suppress the poll at this boundary |
| cpu_if | input | 1 | Processor interrupt-enable flag |
| irq_accept | input | 1 | One-cycle strobe taking the current request |
| wake | output | 1 | One-cycle halt-release pulse |
| irq_req | output | 1 | Interrupt request, held until accepted |
| irq_vector | output | 8 | Vector number carried by the request |

## Verification
The hardest situation to reach from the ports is a request that is already held while further allowed boundaries arrive and a higher-priority source becomes pending. The stimulus first creates a request from a low-index source. It then raises higher-index sources and issues several boundaries before the accept, and checks that the held vector does not move while wake pulses keep coming. Only after the accept does the next boundary deliver the new winner. The wrap of base plus index past 0xFF is reached by writing a colour-mode base of 0xFE.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int NSRC = 8;
  parameter int DW   = 8;
  parameter int AW   = 8;
  localparam int IDXW = $clog2(NSRC);

  localparam logic [AW-1:0] P_BASE   = AW'('hB0);
  localparam logic [AW-1:0] P_ENABLE = AW'('hB2);
  localparam logic [AW-1:0] P_STATUS = AW'('hB4);
  localparam logic [AW-1:0] P_ACK    = AW'('hB6);

  localparam logic [DW-1:0] MONO_KEEP  = ~DW'(7);
  localparam logic [DW-1:0] COLOR_KEEP = ~DW'(1);
  localparam logic [DW-1:0] MONO_FORCE = DW'(3);
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            color_mode,
  input  logic            io_wr,
  input  logic [AW-1:0]   io_addr,
  input  logic [DW-1:0]   io_wdata,
  input  logic [NSRC-1:0] src_set,
  input  logic [NSRC-1:0] src_clr,
  output logic [DW-1:0]   io_rdata,
  output logic [DW-1:0]   base_q,
  output logic [NSRC-1:0] enable_q,
  output logic [NSRC-1:0] status_q
);
  logic [DW-1:0]   base_d;
  logic [NSRC-1:0] enable_d, status_d, ack_bits;
  logic            base_en, enable_en, status_en;

  always_comb begin
    base_en   = io_wr && (io_addr == P_BASE);
    enable_en = io_wr && (io_addr == P_ENABLE);
    ack_bits  = (io_wr && (io_addr == P_ACK)) ? io_wdata[NSRC-1:0] : '0;
    base_d    = io_wdata & (color_mode ? COLOR_KEEP : MONO_KEEP);
    enable_d  = io_wdata[NSRC-1:0];
    status_d  = (status_q & ~ack_bits & ~src_clr) | src_set;
    status_en = (|src_set) || (|src_clr) || (|ack_bits);
  end

  always_comb begin
    io_rdata = '0;
    case (io_addr)
      P_BASE:   io_rdata = color_mode ? base_q : (base_q | MONO_FORCE);
      P_ENABLE: io_rdata = DW'(enable_q);
      P_STATUS: io_rdata = DW'(status_q);
      default:  io_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      enable_q <= '0;
      status_q <= '0;
    end else begin
      if (base_en)   base_q   <= base_d;
      if (enable_en) enable_q <= enable_d;
      if (status_en) status_q <= status_d;
    end
  end

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((status_q & $past(src_set)) == $past(src_set)));
  a_r2_mono_base_low: assert property (@(posedge clk) disable iff (!rst_n)
    (base_en && !color_mode) |=> (base_q[2:0] == 3'b000));
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == P_ACK && !(|src_set)) |=>
      ((status_q & $past(io_wdata[NSRC-1:0])) == '0));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NSRC-1:0] pending,
  input  logic [DW-1:0]   base,
  output logic            any,
  output logic [DW-1:0]   vector
);
  logic [IDXW-1:0] win;

  always_comb begin
    win = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pending[i]) win = IDXW'(i);
    end
    any    = |pending;
    vector = base + DW'(win);
  end
endmodule

// File: rtl/irq_poll.sv
module irq_poll
  import irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          inhibit,
  input  logic          cpu_if,
  input  logic          irq_accept,
  input  logic          any,
  input  logic [DW-1:0] vec_in,
  output logic          wake,
  output logic          irq_req,
  output logic [DW-1:0] irq_vector
);
  logic          poll_ok, wake_d, req_d, vec_en;
  logic [DW-1:0] vec_d;

  always_comb begin
    poll_ok = boundary && !inhibit && any;
    wake_d  = poll_ok;
    req_d   = irq_req;
    vec_en  = 1'b0;
    vec_d   = vec_in;
    if (irq_accept) begin
      req_d = 1'b0;
    end else if (!irq_req && poll_ok && cpu_if) begin
      req_d  = 1'b1;
      vec_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake       <= 1'b0;
      irq_req    <= 1'b0;
      irq_vector <= '0;
    end else begin
      wake    <= wake_d;
      irq_req <= req_d;
      if (vec_en) irq_vector <= vec_d;
    end
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_accept) |=> (irq_req && $stable(irq_vector)));
  a_r11_drop: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |=> !irq_req);
  a_r10_needs_if: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(cpu_if));
  a_r9_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && inhibit) |=> (!wake && !$rose(irq_req)));
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            color_mode,
  input  logic            io_wr,
  input  logic [AW-1:0]   io_addr,
  input  logic [DW-1:0]   io_wdata,
  output logic [DW-1:0]   io_rdata,
  input  logic [NSRC-1:0] src_set,
  input  logic [NSRC-1:0] src_clr,
  input  logic            boundary,
  input  logic            inhibit,
  input  logic            cpu_if,
  input  logic            irq_accept,
  output logic            wake,
  output logic            irq_req,
  output logic [DW-1:0]   irq_vector
);
  logic [DW-1:0]   base_q, vec_c;
  logic [NSRC-1:0] enable_q, status_q;
  logic            any_c;

  irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .color_mode(color_mode), .io_wr(io_wr),
    .io_addr(io_addr), .io_wdata(io_wdata), .src_set(src_set), .src_clr(src_clr),
    .io_rdata(io_rdata), .base_q(base_q), .enable_q(enable_q), .status_q(status_q)
  );

  irq_arbiter u_arb (
    .pending(status_q & enable_q), .base(base_q), .any(any_c), .vector(vec_c)
  );

  irq_poll u_poll (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .inhibit(inhibit),
    .cpu_if(cpu_if), .irq_accept(irq_accept), .any(any_c), .vec_in(vec_c),
    .wake(wake), .irq_req(irq_req), .irq_vector(irq_vector)
  );

  a_r7_wake_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake) |-> $past(|(status_q & enable_q)));
  a_r8_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(boundary && !inhibit));
endmodule

// File: tb/sim_irq_ctrl_top.sv
module sim_irq_ctrl_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       color_mode = 1'b1, io_wr = 1'b0;
  logic [7:0] io_addr = 8'h00, io_wdata = 8'h00, io_rdata;
  logic [7:0] src_set = 8'h00, src_clr = 8'h00;
  logic       boundary = 1'b0, inhibit = 1'b0, cpu_if = 1'b0, irq_accept = 1'b0;
  logic       wake, irq_req;
  logic [7:0] irq_vector;

  int total = 0, bad = 0;
  int wake_seen = 0, exp_wake = 0;
  logic [7:0] exp_q[$];
  logic prev_req = 1'b0;

  always #5 clk = ~clk;

  irq_ctrl_top u0 (
    .clk(clk), .rst_n(rst_n), .color_mode(color_mode), .io_wr(io_wr),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .src_set(src_set), .src_clr(src_clr), .boundary(boundary), .inhibit(inhibit),
    .cpu_if(cpu_if), .irq_accept(irq_accept), .wake(wake), .irq_req(irq_req),
    .irq_vector(irq_vector)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // monitor: pops expected vectors on each new request, counts wake pulses
  always @(negedge clk) begin
    if (rst_n) begin
      if (wake) wake_seen++;
      if (irq_req && !prev_req) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R10 unexpected request got=%h exp=none", irq_vector);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (irq_vector !== e) begin
            bad++;
            $display("FAIL R10 vector got=%h exp=%h", irq_vector, e);
          end
        end
      end
      prev_req = irq_req;
    end
  end

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    io_wr = 1'b1; io_addr = a; io_wdata = d; step(); io_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    io_addr = a; #1; chk(tag, io_rdata, exp);
  endtask

  task automatic strobe(input logic [7:0] s, input logic [7:0] c);
    src_set = s; src_clr = c; step(); src_set = '0; src_clr = '0;
  endtask

  // driver: one boundary; pushes the expected vector when a request must follow
  task automatic poll(input logic inh, input logic [7:0] exp_vec, input logic want_req,
                      input logic want_wake);
    inhibit = inh; boundary = 1'b1;
    if (want_req) exp_q.push_back(exp_vec);
    if (want_wake) exp_wake++;
    step(); boundary = 1'b0; inhibit = 1'b0;
    step();
  endtask

  task automatic accept();
    irq_accept = 1'b1; step(); irq_accept = 1'b0;
    chk("R11 req low after accept", {7'd0, irq_req}, 8'h00);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1
    chk("R1 req", {7'd0, irq_req}, 8'h00);
    chk("R1 wake", {7'd0, wake}, 8'h00);
    rd("R1 base", 8'hB0, 8'h00);
    rd("R1 enable", 8'hB2, 8'h00);
    rd("R1 status", 8'hB4, 8'h00);
    color_mode = 1'b0; rd("R1 mono base", 8'hB0, 8'h03);
    // R2 / R3
    wr(8'hB0, 8'hFF);
    rd("R3 mono read", 8'hB0, 8'hFB);
    color_mode = 1'b1; rd("R2 mono write", 8'hB0, 8'hF8);
    wr(8'hB0, 8'hFF);
    rd("R2 color write", 8'hB0, 8'hFE);
    color_mode = 1'b0; rd("R3 mono force", 8'hB0, 8'hFF);
    color_mode = 1'b1;
    // R4
    wr(8'hB2, 8'hA5);
    rd("R4 enable rw", 8'hB2, 8'hA5);
    rd("R4 other port", 8'h10, 8'h00);
    rd("R4 ack port read", 8'hB6, 8'h00);
    // R6
    strobe(8'h81, 8'h00); rd("R6 set", 8'hB4, 8'h81);
    strobe(8'h00, 8'h01); rd("R6 clear", 8'hB4, 8'h80);
    src_set = 8'h04; io_wr = 1'b1; io_addr = 8'hB6; io_wdata = 8'h04;
    step(); src_set = '0; io_wr = 1'b0;
    rd("R6 set beats ack", 8'hB4, 8'h84);
    strobe(8'h02, 8'h02); rd("R6 set beats clear", 8'hB4, 8'h86);
    // R5
    wr(8'hB6, 8'h82); rd("R5 ack", 8'hB4, 8'h04);
    wr(8'hB6, 8'h00); rd("R5 ack zero", 8'hB4, 8'h04);
    // R7: status 0x04 but enable 0
    wr(8'hB2, 8'h00);
    cpu_if = 1'b1;
    poll(1'b0, 8'h00, 1'b0, 1'b0);
    chk("R7 masked no wake", 8'(wake_seen), 8'(exp_wake));
    // R8: wake with cpu_if clear, no request
    wr(8'hB2, 8'h04);
    cpu_if = 1'b0;
    poll(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R8 wake count", 8'(wake_seen), 8'(exp_wake));
    chk("R8 no req", {7'd0, irq_req}, 8'h00);
    // R9: inhibited boundary
    cpu_if = 1'b1;
    poll(1'b1, 8'h00, 1'b0, 1'b0);
    chk("R9 no wake", 8'(wake_seen), 8'(exp_wake));
    chk("R9 no req", {7'd0, irq_req}, 8'h00);
    // R10: wrap FE + 2
    wr(8'hB0, 8'hFE);
    poll(1'b0, 8'h00, 1'b1, 1'b1);
    chk("R10 req up", {7'd0, irq_req}, 8'h01);
    // R11: higher sources arrive while held
    wr(8'hB2, 8'hFF);
    strobe(8'hA0, 8'h00);
    poll(1'b0, 8'h00, 1'b0, 1'b1);
    poll(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R11 vector held", irq_vector, 8'h00);
    chk("R11 req held", {7'd0, irq_req}, 8'h01);
    chk("R8 wake while held", 8'(wake_seen), 8'(exp_wake));
    accept();
    poll(1'b0, 8'h05, 1'b1, 1'b1);
    accept();
    wr(8'hB6, 8'h80);
    poll(1'b0, 8'h03, 1'b1, 1'b1);
    accept();
    color_mode = 1'b0;
    wr(8'hB0, 8'h47);
    wr(8'hB6, 8'h20);
    poll(1'b0, 8'h42, 1'b1, 1'b1);
    accept();
    step();
    chk("R10 all vectors seen", 8'(exp_q.size()), 8'h00);
    chk("R8 final wake count", 8'(wake_seen), 8'(exp_wake));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule